// File: doc/BRIEF.md
# Sixteen-bit ALU with registered condition flags

This block is the arithmetic and logic unit of a microcoded processor datapath. It takes two 16-bit operands, a 4-bit operation code, a 4-bit right-shift amount, an incoming carry and a third 16-bit operand that only the masked-rotate operation uses. From these it forms a 16-bit result without any clock delay. It also keeps four condition flags (carry, overflow, negative, zero) in a register that changes only on a clock edge.

The flags change through one of two paths. The update path, enabled by `flag_upd`, captures the flags of the current operation. The load path, enabled by `flag_load`, takes a word that arrives from elsewhere, clears carry and overflow, and derives negative and zero from that word. Choosing the operands, writing the result back and decoding instructions are left to the surrounding datapath.

The flag register has two named states of control: HOLD (neither enable is high) and CAPTURE (one enable is high). In CAPTURE the load path wins over the update path.

Top module: `wordalu_core`

## Requirements
- R1: Bitwise operations by code: 0 gives A, 1 gives A AND NOT B, 2 gives A AND B, 3 gives NOT (A OR B), 4 gives A OR B, 5 gives A XOR B.
- R2: Code 6 rotates A right by `shamt` (0 to 15). Code 14 shifts A right arithmetically by `shamt` and fills the vacated bits with bit 15 of A.
- R3: Code 7 gives A AND (M rotated right by `shamt`).
- R4: Code 9 adds B to A. Code 10 first forms B' = (B + `cin`) mod 65536 and then adds B' to A. Carry is bit 16 of the 17-bit sum. Overflow is bit 15 of (NOT(A XOR B') AND (B' XOR result)), where B' = B for code 9.
- R5: Code 11 subtracts B from A. Code 12 subtracts B' = (B + `cin`) mod 65536 from A. Carry is set exactly when A < B' as unsigned numbers. Overflow is bit 15 of ((A XOR B') AND (NOT B' XOR result)).
- R6: Code 13 gives A+1, with carry set only when A = 0xFFFF and overflow set only when the result is 0x8000. Code 8 gives A-1, with carry set only when A = 0 and overflow set only when the result is 0x7FFF.
- R7: Codes 0 to 7 and 14 produce carry = 0 and overflow = 0. For every code, negative is bit 15 of the result and zero is set exactly when the result is 0.
- R8: Code 15 gives a result of 0.
- R9: Reset clears all four flags. When `flag_upd` is high, the flags take the current operation's values at the next rising clock edge. When both enables are low, the flags keep their values.
- R10: When `flag_load` is high, the flags at the next edge are carry = 0, overflow = 0, negative = `load_word` bit 15, and zero = (`load_word` == 0), whatever the value of `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation select (codes in R1 to R8) |
| shamt | input | 4 | Rotate or shift amount |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| opm | input | 16 | Masked-rotate source operand |
| cin | input | 1 | Incoming carry for codes 10 and 12 |
| flag_upd | input | 1 | Capture the operation's flags |
| flag_load | input | 1 | Load-path flag capture |
| load_word | input | 16 | Word that sets N and Z on the load path |
| result | output | 16 | Combinational result |
| flag_c | output | 1 | Registered carry |
| flag_v | output | 1 | Registered overflow |
| flag_n | output | 1 | Registered negative |
| flag_z | output | 1 | Registered zero |

## Verification
The two functions that can occur in the same cycle are the update path and the load path. The bench raises `flag_upd` and `flag_load` together several times. In those cycles the operation's own flags differ from the flags the load word would give, for example an addition with a carry-out against a negative load word. The bench then checks that the flags after the edge match the load word and not the operation. A behavioural model in the bench also predicts every cycle's result and next flags, and compares them against the design.

// File: rtl/wordalu_pkg.sv
`timescale 1ns/1ps
package wordalu_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ANDN = 4'd1,
        OP_AND  = 4'd2,
        OP_NOR  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_ROR  = 4'd6,
        OP_MROR = 4'd7,
        OP_DEC  = 4'd8,
        OP_ADD  = 4'd9,
        OP_ADDC = 4'd10,
        OP_SUB  = 4'd11,
        OP_SUBC = 4'd12,
        OP_INC  = 4'd13,
        OP_ASR  = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        FL_HOLD    = 2'd0,
        FL_CAPTURE = 2'd1,
        FL_LOAD    = 2'd2
    } flag_mode_e;

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_DEC) || (op == OP_ADD) || (op == OP_ADDC) ||
               (op == OP_SUB) || (op == OP_SUBC) || (op == OP_INC);
    endfunction

endpackage

// File: rtl/wordalu_logic.sv
`timescale 1ns/1ps
module wordalu_logic
    import wordalu_pkg::*;
#(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   m,
    input  logic [SW-1:0]  amt,
    output logic [W-1:0]   y
);

    logic [2*W-1:0] a_dbl;
    logic [2*W-1:0] m_dbl;
    logic [W-1:0]   a_rot;
    logic [W-1:0]   m_rot;
    logic [W-1:0]   a_asr;

    always_comb begin
        a_dbl = {a, a} >> amt;
        m_dbl = {m, m} >> amt;
        a_rot = a_dbl[W-1:0];
        m_rot = m_dbl[W-1:0];
        a_asr = W'($signed(a) >>> amt);
    end

    always_comb begin
        unique case (op)
            OP_PASS: y = a;
            OP_ANDN: y = a & ~b;
            OP_AND:  y = a & b;
            OP_NOR:  y = ~(a | b);
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ROR:  y = a_rot;
            OP_MROR: y = a & m_rot;
            OP_ASR:  y = a_asr;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/wordalu_arith.sv
`timescale 1ns/1ps
module wordalu_arith
    import wordalu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           co,
    output logic           vo
);

    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] MSB_ONLY = ONE << (W-1);
    localparam logic [W-1:0] MSB_CLR  = ~MSB_ONLY;

    logic [W-1:0] b_eff;
    logic [W:0]   raw;
    logic         with_cin;

    always_comb begin
        with_cin = (op == OP_ADDC) || (op == OP_SUBC);
        b_eff    = with_cin ? (b + W'(cin)) : b;
        unique case (op)
            OP_ADD, OP_ADDC: raw = {1'b0, a} + {1'b0, b_eff};
            OP_SUB, OP_SUBC: raw = {1'b0, a} - {1'b0, b_eff};
            OP_INC:          raw = {1'b0, a} + {1'b0, ONE};
            OP_DEC:          raw = {1'b0, a} - {1'b0, ONE};
            default:         raw = '0;
        endcase
        y  = raw[W-1:0];
        co = raw[W];
        unique case (op)
            OP_ADD, OP_ADDC: vo = (~(a ^ b_eff) & (b_eff ^ y)) >> (W-1) != '0;
            OP_SUB, OP_SUBC: vo = ((a ^ b_eff) & (~b_eff ^ y)) >> (W-1) != '0;
            OP_INC:          vo = (y == MSB_ONLY);
            OP_DEC:          vo = (y == MSB_CLR);
            default:         vo = 1'b0;
        endcase
    end

endmodule

// File: rtl/wordalu_flags.sv
`timescale 1ns/1ps
module wordalu_flags
    import wordalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          load_en,
    input  logic [W-1:0]  load_word,
    input  logic [W-1:0]  res_in,
    input  logic          c_in,
    input  logic          v_in,
    output logic          c_q,
    output logic          v_q,
    output logic          n_q,
    output logic          z_q
);

    flag_mode_e mode;
    logic c_d, v_d, n_d, z_d;

    always_comb begin
        if (load_en)     mode = FL_LOAD;
        else if (upd_en) mode = FL_CAPTURE;
        else             mode = FL_HOLD;
    end

    always_comb begin
        unique case (mode)
            FL_LOAD: begin
                c_d = 1'b0;
                v_d = 1'b0;
                n_d = load_word[W-1];
                z_d = (load_word == '0);
            end
            FL_CAPTURE: begin
                c_d = c_in;
                v_d = v_in;
                n_d = res_in[W-1];
                z_d = (res_in == '0);
            end
            default: begin
                c_d = c_q;
                v_d = v_q;
                n_d = n_q;
                z_d = z_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            v_q <= 1'b0;
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            c_q <= c_d;
            v_q <= v_d;
            n_q <= n_d;
            z_q <= z_d;
        end
    end

    // R10
    load_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (!c_q && !v_q));

    // R10
    load_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (n_q == $past(load_word[W-1])) && (z_q == ($past(load_word) == '0)));

    // R9
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !upd_en) |=> $stable({c_q, v_q, n_q, z_q}));

    // R7
    capture_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en) |=> (z_q == ($past(res_in) == '0)));

endmodule

// File: rtl/wordalu_core.sv
`timescale 1ns/1ps
module wordalu_core
    import wordalu_pkg::*;
#(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_code,
    input  logic [SW-1:0] shamt,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  opm,
    input  logic          cin,
    input  logic          flag_upd,
    input  logic          flag_load,
    input  logic [W-1:0]  load_word,
    output logic [W-1:0]  result,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_n,
    output logic          flag_z
);

    alu_op_e      op;
    logic [W-1:0] y_logic;
    logic [W-1:0] y_arith;
    logic         c_arith;
    logic         v_arith;
    logic         c_sel;
    logic         v_sel;

    assign op = alu_op_e'(op_code);

    wordalu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .m   (opm),
        .amt (shamt),
        .y   (y_logic)
    );

    wordalu_arith #(.W(W)) u_arith (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .cin (cin),
        .y   (y_arith),
        .co  (c_arith),
        .vo  (v_arith)
    );

    always_comb begin
        if (is_arith(op)) begin
            result = y_arith;
            c_sel  = c_arith;
            v_sel  = v_arith;
        end else begin
            result = y_logic;
            c_sel  = 1'b0;
            v_sel  = 1'b0;
        end
    end

    wordalu_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (flag_upd),
        .load_en   (flag_load),
        .load_word (load_word),
        .res_in    (result),
        .c_in      (c_sel),
        .v_in      (v_sel),
        .c_q       (flag_c),
        .v_q       (flag_v),
        .n_q       (flag_n),
        .z_q       (flag_z)
    );

    // R8
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd15) |-> (result == '0));

    // R6
    inc_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && v_arith) |-> (opa == ~(W'(1) << (W-1))));

    // R7
    logic_no_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !flag_load && !is_arith(op)) |=> (!flag_c && !flag_v));

endmodule

// File: tb/sim_wordalu_core.sv
`timescale 1ns/1ps
module sim_wordalu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  shamt = '0;
    logic [15:0] opa = '0, opb = '0, opm = '0, load_word = '0;
    logic        cin = 1'b0, flag_upd = 1'b0, flag_load = 1'b0;
    logic [15:0] result;
    logic        flag_c, flag_v, flag_n, flag_z;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_f = 4'b0;   // {c,v,n,z}
    logic [31:0] seed = 32'h1234_abcd;
    logic done = 1'b0;

    always #4 clk = ~clk;

    wordalu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .shamt(shamt),
        .opa(opa), .opb(opb), .opm(opm), .cin(cin),
        .flag_upd(flag_upd), .flag_load(flag_load), .load_word(load_word),
        .result(result), .flag_c(flag_c), .flag_v(flag_v),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R1";
            4'd6, 4'd14: return "R2";
            4'd7: return "R3";
            4'd9, 4'd10: return "R4";
            4'd11, 4'd12: return "R5";
            4'd8, 4'd13: return "R6";
            default: return "R8";
        endcase
    endfunction

    // returns {v, c, result}
    function automatic logic [17:0] ref_eval(input logic [3:0] o, input logic [15:0] a, b, m,
                                             input logic [3:0] k, input logic ci);
        int ai, bi, s;
        logic [15:0] r, bb;
        logic c, v;
        ai = int'(a);
        bi = int'(b);
        c = 1'b0;
        v = 1'b0;
        r = 16'h0;
        bb = ((o == 4'd10) || (o == 4'd12)) ? 16'((bi + int'(ci)) % 65536) : b;
        case (o)
            4'd0: r = a;
            4'd1: r = a & ~b;
            4'd2: r = a & b;
            4'd3: r = ~(a | b);
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6: for (int i = 0; i < 16; i++) r[i] = a[(i + int'(k)) % 16];
            4'd7: begin
                for (int i = 0; i < 16; i++) r[i] = m[(i + int'(k)) % 16];
                r = r & a;
            end
            4'd14: for (int i = 0; i < 16; i++)
                       r[i] = (i + int'(k) < 16) ? a[i + int'(k)] : a[15];
            4'd9, 4'd10: begin
                s = ai + int'(bb);
                r = 16'(s % 65536);
                c = (s >= 65536);
                v = (a[15] == bb[15]) && (r[15] != a[15]);
            end
            4'd11, 4'd12: begin
                s = ai - int'(bb);
                c = (s < 0);
                r = 16'((s + 65536) % 65536);
                v = (a[15] != bb[15]) && (r[15] != a[15]);
            end
            4'd13: begin
                r = 16'((ai + 1) % 65536);
                c = (ai == 65535);
                v = (r == 16'h8000);
            end
            4'd8: begin
                r = 16'((ai + 65535) % 65536);
                c = (ai == 0);
                v = (r == 16'h7fff);
            end
            default: r = 16'h0;
        endcase
        return {v, c, r};
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [15:0] a, b, m,
                        input logic [3:0] k, input logic ci, fu, fl,
                        input logic [15:0] w);
        logic [17:0] r;
        string tag;
        @(negedge clk);
        op_code = o; opa = a; opb = b; opm = m; shamt = k; cin = ci;
        flag_upd = fu; flag_load = fl; load_word = w;
        #1;
        r = ref_eval(o, a, b, m, k, ci);
        check(req_of(o), "result", result, r[15:0]);
        if (fl) begin
            exp_f = {1'b0, 1'b0, w[15], (w == 16'h0)};
            tag = "R10";
        end else if (fu) begin
            exp_f = {r[16], r[17], r[15], (r[15:0] == 16'h0)};
            tag = (o == 4'd15) ? "R8" : (r[16] || r[17]) ? req_of(o) : "R7";
        end else begin
            tag = "R9";
        end
        @(posedge clk);
        #1;
        check(tag, "flags cvnz", {12'h0, flag_c, flag_v, flag_n, flag_z}, {12'h0, exp_f});
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9", "reset flags", {12'h0, flag_c, flag_v, flag_n, flag_z}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 bitwise
        for (int o = 0; o < 6; o++)
            step(4'(o), 16'hF0A5, 16'h3C69, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd3, 16'h0, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        // R2 rotate and arithmetic shift
        step(4'd6, 16'h8001, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd6, 16'h8001, 16'h0, 16'h0, 4'd1, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd6, 16'h8001, 16'h0, 16'h0, 4'd15, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd14, 16'h8000, 16'h0, 16'h0, 4'd15, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd14, 16'h7F00, 16'h0, 16'h0, 4'd4, 1'b0, 1'b1, 1'b0, 16'h0);
        // R3 masked rotate
        step(4'd7, 16'h0FF0, 16'hFFFF, 16'h1234, 4'd4, 1'b0, 1'b1, 1'b0, 16'h0);
        // R4 add and add with carry
        step(4'd9, 16'h7FFF, 16'h0001, 16'h0, 4'd0, 1'b1, 1'b1, 1'b0, 16'h0);
        step(4'd9, 16'hFFFF, 16'h0001, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd10, 16'h0005, 16'hFFFF, 16'h0, 4'd0, 1'b1, 1'b1, 1'b0, 16'h0);
        step(4'd10, 16'h8000, 16'h7FFF, 16'h0, 4'd0, 1'b1, 1'b1, 1'b0, 16'h0);
        // R5 subtract and subtract with carry
        step(4'd11, 16'h0000, 16'h0001, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd11, 16'h8000, 16'h0001, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd12, 16'h0003, 16'h0002, 16'h0, 4'd0, 1'b1, 1'b1, 1'b0, 16'h0);
        step(4'd12, 16'h0003, 16'hFFFF, 16'h0, 4'd0, 1'b1, 1'b1, 1'b0, 16'h0);
        // R6 increment and decrement
        step(4'd13, 16'h7FFF, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd13, 16'hFFFF, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd8, 16'h8000, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd8, 16'h0000, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        // R8 unused code
        step(4'd15, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'd3, 1'b1, 1'b1, 1'b0, 16'h0);
        // R9 hold: set carry, then operate with enables low
        step(4'd9, 16'hFFFF, 16'h0002, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        step(4'd0, 16'h0000, 16'h0, 16'h0, 4'd0, 1'b0, 1'b0, 1'b0, 16'h8000);
        step(4'd3, 16'h1234, 16'h0, 16'h0, 4'd0, 1'b0, 1'b0, 1'b0, 16'h0);
        // R10 load wins over update in the same cycle
        step(4'd9, 16'hFFFF, 16'h0001, 16'h0, 4'd0, 1'b0, 1'b1, 1'b1, 16'h8001);
        step(4'd13, 16'h7FFF, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b1, 16'h0000);
        step(4'd11, 16'h0000, 16'h0005, 16'h0, 4'd0, 1'b0, 1'b0, 1'b1, 16'h0042);

        // pseudo-random mix of all codes and enables
        for (int i = 0; i < 600; i++) begin
            logic [31:0] s1, s2, s3;
            seed = nxt(seed); s1 = seed;
            seed = nxt(seed); s2 = seed;
            seed = nxt(seed); s3 = seed;
            step(s1[27:24], s1[15:0], s2[15:0], s3[15:0], s2[27:24], s3[28],
                 s1[30] | s1[29], s2[31] & s3[31], s3[27:12]);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule